// File: doc/BRIEF.md
# Reset Cause and Clock-Security Status Register

This block is one 8-bit register on the CPU's peripheral bus. It records why the chip last came out of reset: a low-voltage event, a watchdog timeout or the external reset pin. It also reports and gates clock-security events. A clock-security event means the main oscillator was disturbed and hardware switched the core to a backup oscillator. The reset generator, the disturbance detector and the oscillator switch sit outside the block and reach it as pulses.

Each warm reset reaches the block as a one-cycle event strobe with a 2-bit kind code. The strobe updates the two sticky cause flags and returns the volatile control and status bits to 0. `rst_n` is the power-on reset and clears every bit. Two option-byte inputs can switch the clock-security logic and the low-voltage flag off.

The bus is a plain read/write strobe pair on a single register. There are no streaming interfaces. A read completes in the cycle it is asserted, with combinational read data, so there is no back-pressure and every pin is plain control or status.

Top module: `rst_cause_css`

## Requirements
- R1: Bits 7, 6, 5 and 3 of the read data are always 0, and writing 1 to them changes nothing.
- R2: Bit 4 (low-voltage flag) sets on an event strobe with kind code 2'b10. It clears only when a write carries 0 in bit 4. Writing 1 to bit 4 leaves it unchanged.
- R3: Once bit 4 is set, event strobes with kind 2'b00, 2'b01 or 2'b11 leave it set.
- R4: Bit 0 (watchdog flag) sets on an event strobe with kind 2'b01. It clears when a write carries 0 in bit 0, or on an event strobe with kind 2'b10. Writing 1 to bit 0 leaves it unchanged.
- R5: Event strobes with kind 2'b00 or 2'b11 (external pin) change neither bit 4 nor bit 0.
- R6: Bit 2 (clock-security interrupt enable) reads back the last value written to it. Power-on reset clears all eight bits.
- R7: Bit 1 (safe-oscillator flag) sets on a disturbance pulse. A read clears it only if `osc_recovered` is high in the same cycle. Writes never change it.
- R8: While `opt_css_en` is low, bit 1 is forced to 0 on the next edge and `css_irq` is low.
- R9: While `opt_lvd_en` is low, bit 4 is held at 0 from the next edge on.
- R10: When a hardware set and a software clear hit the same flag on one edge, the flag ends set. This covers a watchdog strobe with a 0-write to bit 0, a low-voltage strobe with a 0-write to bit 4, and a disturbance pulse with a recovered read.
- R11: `css_irq` is the AND of bit 2, bit 1 and `opt_css_en`, registered once. It rises the cycle after all three are 1 and drops the cycle after any of them clears.
- R12: Any event strobe clears bit 2 and bit 1 on its edge. It wins over a write to bit 2 and over a disturbance pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| rst_evt | input | 1 | One-cycle warm-reset event strobe |
| rst_kind | input | 2 | Kind of reset event: 00/11 pin, 01 watchdog, 10 low-voltage |
| css_disturb | input | 1 | Pulse: main clock disturbed, safe oscillator selected |
| osc_recovered | input | 1 | Main oscillator is running normally again |
| opt_css_en | input | 1 | Option byte: clock-security logic enabled |
| opt_lvd_en | input | 1 | Option byte: low-voltage detector enabled |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register contents |
| css_irq | output | 1 | Clock-security interrupt request |

## Verification
The bench goes after the asymmetric stickiness. It runs every ordered pair of reset kinds with the low-voltage option on and off, so a design where an external or watchdog reset wiped the low-voltage flag, or where a low-voltage reset left a stale watchdog flag, shows a wrong flag pair. All 256 write values are applied over set flags: a design that let a written 1 set a flag, or let reserved bits stick, reads back the wrong byte. An exhaustive sweep over the same-cycle combinations of event strobe, disturbance, recovery, read and write, taken with the clock-security option on and off, catches read-clears that ignore recovery, software clears that beat hardware sets, and an interrupt that lags or leads its flag by a cycle.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  localparam int REG_W = 8;

  localparam int POS_WDOG = 0;
  localparam int POS_SAFE = 1;
  localparam int POS_IEN  = 2;
  localparam int POS_LVD  = 4;

  localparam logic [REG_W-1:0] LIVE_MASK =
    (REG_W'(1) << POS_WDOG) | (REG_W'(1) << POS_SAFE) |
    (REG_W'(1) << POS_IEN)  | (REG_W'(1) << POS_LVD);
  localparam logic [REG_W-1:0] RSVD_MASK = ~LIVE_MASK;

  typedef enum logic [1:0] {
    KIND_PIN  = 2'b00,
    KIND_WDOG = 2'b01,
    KIND_LVD  = 2'b10,
    KIND_PINB = 2'b11
  } rst_kind_e;

endpackage

// File: rtl/rcs_reset_flags.sv
module rcs_reset_flags
  import rcs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      evt,
  input  rst_kind_e kind,
  input  logic      lvd_en,
  input  logic      clr_lvd,
  input  logic      clr_wdog,
  output logic      lvd_flag,
  output logic      wdog_flag
);

  logic set_lvd, set_wdog;
  assign set_lvd  = evt && (kind == KIND_LVD);
  assign set_wdog = evt && (kind == KIND_WDOG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            lvd_flag <= 1'b0;
    else if (!lvd_en)      lvd_flag <= 1'b0;
    else if (set_lvd)      lvd_flag <= 1'b1;
    else if (clr_lvd)      lvd_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wdog_flag <= 1'b0;
    else if (set_lvd)      wdog_flag <= 1'b0;
    else if (set_wdog)     wdog_flag <= 1'b1;
    else if (clr_wdog)     wdog_flag <= 1'b0;
  end

  AST_LVD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lvd_flag && lvd_en && !clr_lvd) |=> lvd_flag); // R3
  AST_LVD_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (lvd_en && evt && kind == KIND_LVD) |=> lvd_flag); // R10
  AST_LVD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !lvd_en |=> !lvd_flag); // R9
  AST_WDOG_LVD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && kind == KIND_LVD) |=> !wdog_flag); // R4
  AST_WDOG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && kind == KIND_WDOG) |=> wdog_flag); // R10
  AST_PIN_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && (kind == KIND_PIN || kind == KIND_PINB) && !clr_wdog)
      |=> $stable(wdog_flag)); // R5

endmodule

// File: rtl/rcs_clock_guard.sv
module rcs_clock_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic disturb,
  input  logic recovered,
  input  logic css_en,
  input  logic rd,
  input  logic wr,
  input  logic wr_ien,
  output logic ien,
  output logic safe_flag,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ien <= 1'b0;
    else if (evt)  ien <= 1'b0;
    else if (wr)   ien <= wr_ien;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  safe_flag <= 1'b0;
    else if (!css_en)            safe_flag <= 1'b0;
    else if (evt)                safe_flag <= 1'b0;
    else if (disturb)            safe_flag <= 1'b1;
    else if (rd && recovered)    safe_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= ien & safe_flag & css_en;
  end

  AST_SAFE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (safe_flag && css_en && !evt && !(rd && recovered)) |=> safe_flag); // R7
  AST_SAFE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (css_en && !evt && disturb) |=> safe_flag); // R10
  AST_CSS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !css_en |=> (!safe_flag && !irq)); // R8
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ien && safe_flag && css_en) |=> irq); // R11
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(safe_flag) |=> !irq); // R11
  AST_EVT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (!ien && !safe_flag)); // R12

endmodule

// File: rtl/rcs_read_mux.sv
module rcs_read_mux
  import rcs_pkg::*;
(
  input  logic             lvd_flag,
  input  logic             ien,
  input  logic             safe_flag,
  input  logic             wdog_flag,
  output logic [REG_W-1:0] rdata
);

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (i == POS_LVD) begin : g_lvd
      assign rdata[i] = lvd_flag;
    end else if (i == POS_IEN) begin : g_ien
      assign rdata[i] = ien;
    end else if (i == POS_SAFE) begin : g_safe
      assign rdata[i] = safe_flag;
    end else if (i == POS_WDOG) begin : g_wdog
      assign rdata[i] = wdog_flag;
    end else begin : g_rsvd
      assign rdata[i] = 1'b0;
    end
  end

endmodule

// File: rtl/rst_cause_css.sv
module rst_cause_css
  import rcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_evt,
  input  logic [1:0]       rst_kind,
  input  logic             css_disturb,
  input  logic             osc_recovered,
  input  logic             opt_css_en,
  input  logic             opt_lvd_en,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             css_irq
);

  logic lvd_flag, wdog_flag, ien, safe_flag;
  logic clr_lvd, clr_wdog, rsvd_wr;

  assign clr_lvd  = bus_wr && !bus_wdata[POS_LVD];
  assign clr_wdog = bus_wr && !bus_wdata[POS_WDOG];
  assign rsvd_wr  = bus_wr && |(bus_wdata & RSVD_MASK);

  rcs_reset_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (rst_evt),
    .kind      (rst_kind_e'(rst_kind)),
    .lvd_en    (opt_lvd_en),
    .clr_lvd   (clr_lvd),
    .clr_wdog  (clr_wdog),
    .lvd_flag  (lvd_flag),
    .wdog_flag (wdog_flag)
  );

  rcs_clock_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (rst_evt),
    .disturb   (css_disturb),
    .recovered (osc_recovered),
    .css_en    (opt_css_en),
    .rd        (bus_rd),
    .wr        (bus_wr),
    .wr_ien    (bus_wdata[POS_IEN]),
    .ien       (ien),
    .safe_flag (safe_flag),
    .irq       (css_irq)
  );

  rcs_read_mux u_mux (
    .lvd_flag  (lvd_flag),
    .ien       (ien),
    .safe_flag (safe_flag),
    .wdog_flag (wdog_flag),
    .rdata     (bus_rdata)
  );

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & RSVD_MASK) == '0); // R1
  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_wr |=> (bus_rdata & RSVD_MASK) == '0); // R1
  AST_WRITE_NO_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && !css_disturb && !rst_evt && opt_css_en)
      |=> $stable(bus_rdata[POS_SAFE])); // R7

endmodule

// File: tb/rst_cause_css_bench.sv
`timescale 1ns/1ps
module rst_cause_css_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rst_evt = 1'b0;
  logic [1:0] rst_kind = 2'b00;
  logic       css_disturb = 1'b0, osc_recovered = 1'b0;
  logic       opt_css_en = 1'b1, opt_lvd_en = 1'b1;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       css_irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic m_lv = 0, m_wd = 0, m_en = 0, m_fl = 0, m_irq = 0;

  always #2.5 clk = ~clk;

  rst_cause_css u_rst_cause_css (
    .clk(clk), .rst_n(rst_n), .rst_evt(rst_evt), .rst_kind(rst_kind),
    .css_disturb(css_disturb), .osc_recovered(osc_recovered),
    .opt_css_en(opt_css_en), .opt_lvd_en(opt_lvd_en),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .css_irq(css_irq)
  );

  task automatic check(string tag);
    logic [7:0] exp_d;
    exp_d = {3'b000, m_lv, 1'b0, m_en, m_fl, m_wd};
    checks++;
    if (bus_rdata !== exp_d || css_irq !== m_irq) begin
      errors++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
               tag, bus_rdata, css_irq, exp_d, m_irq);
    end
  endtask

  // one cycle of stimulus, applied at a falling edge, checked at the next
  task automatic step(string tag, bit evt, logic [1:0] kind, bit det, bit rec,
                      bit rd, bit wr, logic [7:0] wd);
    logic n_lv, n_wd, n_en, n_fl, n_irq;
    bit is_lv, is_wd;
    is_lv = evt && kind == 2'b10;
    is_wd = evt && kind == 2'b01;
    n_lv  = !opt_lvd_en ? 1'b0 : is_lv ? 1'b1 : (wr && !wd[4]) ? 1'b0 : m_lv;
    n_wd  = is_lv ? 1'b0 : is_wd ? 1'b1 : (wr && !wd[0]) ? 1'b0 : m_wd;
    n_en  = evt ? 1'b0 : wr ? wd[2] : m_en;
    n_fl  = !opt_css_en ? 1'b0 : evt ? 1'b0 : det ? 1'b1 : (rd && rec) ? 1'b0 : m_fl;
    n_irq = m_en & m_fl & opt_css_en;
    rst_evt = evt; rst_kind = kind; css_disturb = det; osc_recovered = rec;
    bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    rst_evt = 0; css_disturb = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 8'h00;
    m_lv = n_lv; m_wd = n_wd; m_en = n_en; m_fl = n_fl; m_irq = n_irq;
    check(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 2'b00, 0, osc_recovered, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 power-on state");

    // R2 R3 R4 R5 R9: every ordered pair of reset kinds, both option settings
    for (int lo = 0; lo < 2; lo++) begin
      opt_lvd_en = lo[0];
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          step("R2 R4 clear", 0, 2'b00, 0, 0, 0, 1, 8'h00);
          step("R2 R4 R5 R9 first kind", 1, a[1:0], 0, 0, 0, 0, 8'h00);
          step("R3 R4 R5 R9 second kind", 1, b[1:0], 0, 0, 0, 0, 8'h00);
        end
      end
    end
    opt_lvd_en = 1'b1;

    // R1 R2 R4 R6: all write values over set flags
    for (int w = 0; w < 256; w++) begin
      step("R2 set lvd", 1, 2'b10, 0, 0, 0, 0, 8'h00);
      step("R4 set wdog", 1, 2'b01, 0, 0, 0, 0, 8'h00);
      step("R1 R2 R4 R6 write", 0, 2'b00, 0, 0, 0, 1, w[7:0]);
    end

    // R9: option dropped while the flag is set
    step("R2 set lvd", 1, 2'b10, 0, 0, 0, 0, 8'h00);
    opt_lvd_en = 1'b0;
    idle("R9 option off holds 0");
    step("R9 lvd strobe ignored", 1, 2'b10, 0, 0, 0, 0, 8'h00);
    opt_lvd_en = 1'b1;

    // R10: hardware set against software clear
    step("R10 wdog set vs write 0", 1, 2'b01, 0, 0, 0, 1, 8'h00);
    step("R10 lvd set vs write 0", 1, 2'b10, 0, 0, 0, 1, 8'h00);

    // R7 R11: basic clock-security flow
    step("R7 disturb", 0, 2'b00, 1, 0, 0, 0, 8'h00);
    step("R6 enable", 0, 2'b00, 0, 0, 0, 1, 8'h14);
    idle("R11 irq rises");
    step("R7 read, not recovered", 0, 2'b00, 0, 0, 1, 0, 8'h00);
    step("R7 read, recovered", 0, 2'b00, 0, 1, 1, 0, 8'h00);
    idle("R11 irq drops");
    idle("R11 irq stays low");

    // R7 R8 R10 R11 R12: all same-cycle combinations, both option settings
    for (int ce = 0; ce < 2; ce++) begin
      for (int v = 0; v < 32; v++) begin
        opt_css_en = 1'b1;
        step("R7 arm flag", 0, 2'b00, 1, 0, 0, 0, 8'h00);
        step("R6 arm enable", 0, 2'b00, 0, 0, 0, 1, 8'h15);
        opt_css_en = ce[0];
        step("R7 R8 R10 R12 combo", v[4], 2'b00, v[3], v[2], v[1], v[0], 8'h00);
        idle("R8 R11 after combo");
        idle("R11 settle");
      end
    end
    opt_css_en = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule